// File: doc/BRIEF.md
# Running-Sum Edge Smoothing Filter

This block smooths one line of samples that straddles a block edge. Samples are numbered outward from the edge: the near side holds lanes p0 (closest) to p7 (farthest) and the far side holds q0 to q7. The block supports two modes.

- In narrow mode it reads p3..q3 and replaces p2..q2 with rounded averages of eight taps each.
- In wide mode it reads p7..q7 and replaces p6..q6 with rounded averages of sixteen taps each.

Each average is centred on its own lane, counts that lane twice, and repeats the outermost sample read whenever the window runs past it.

The block does not evaluate each average on its own. It first forms one seed sum for the first output, rounding constant included. After that, each cycle it emits one output and moves the sum on by removing two taps and adding two taps. Every tap comes from the line captured at start, never from a sample already rewritten.

The control is a three-state machine:

- IDLE waits for start. Accepting start captures the line, the mode and the enable, and takes the transition IDLE→SEED.
- SEED loads the seed sum, then takes SEED→RUN.
- RUN writes one output lane per cycle. On the last lane it raises done and takes RUN→IDLE.

When enable was low at start, the same sequence runs but no lane is rewritten. The decision of whether a line should be filtered at all belongs to a neighbouring block.

Top module: `deblk_smooth`

## Requirements
- R1: While reset is held and right after it, done is 0 and line_out is all zero.
- R2: Lane i sits at bits [8i+7:8i]; lane 0 is p7, lane 7 is p0, lane 8 is q0 and lane 15 is q7. With wide_mode=0, lanes 5..10 (p2..q2) become (s[t] + Σ_{j=-3..3} s[clamp(t+j,4,11)] + 4) >> 3, where s is the line captured at start and t is the lane written.
- R3: With wide_mode=1, lanes 1..14 (p6..q6) become (s[t] + Σ_{j=-7..7} s[clamp(t+j,0,15)] + 8) >> 4.
- R4: Lanes outside the written set keep the captured input value. In narrow mode these are lanes 0..4 and 11..15; in wide mode they are lanes 0 and 15.
- R5: done is a one-cycle pulse. It is high in the 7th cycle after the clock edge that accepts start in narrow mode, and in the 15th cycle in wide mode.
- R6: When enable is 0 at the accepted start, line_out equals the captured line when done rises, and done keeps the R5 timing.
- R7: A start pulse, or a change of line_in, wide_mode or enable, that arrives while a line is in progress has no effect on the result or on the timing of done.
- R8: In IDLE, line_out holds its value until the next accepted start, whatever line_in does.
- R9: The arithmetic never wraps: an all-255 line gives 255 in every lane and an all-zero line gives 0, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin one line; accepted only in IDLE |
| wide_mode | input | 1 | 0 = eight-tap narrow mode, 1 = sixteen-tap wide mode |
| enable | input | 1 | 0 = pass the line through unchanged |
| line_in | input | 128 | Sixteen 8-bit lanes, p7 in lane 0 through q7 in lane 15 |
| line_out | output | 128 | Result lanes, same layout as line_in |
| done | output | 1 | One-cycle pulse when line_out holds the finished line |

## Verification
The checker assumes that start arrives only as a single-cycle request. It also assumes that the line, the mode and the enable are valid in the cycle start is accepted; values arriving later are ignored by design. The stimulus drives every input on the falling clock edge, holds start high for exactly one cycle per line, and deliberately disturbs line_in and start during a run only in the scenario that targets that behaviour. The latency check counts cycles from the accepted start. This assumes that start is never raised while the block is busy in a way that the checker would count as a new accepted start, and the design's IDLE-only acceptance enforces that.

// File: rtl/deblk_pkg.sv
package deblk_pkg;

    localparam int LINE_TAPS = 16;
    localparam int IDX_W     = $clog2(LINE_TAPS);

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_RUN
    } ctl_state_e;

    typedef struct packed {
        idx_t sub_far;
        idx_t sub_near;
        idx_t add_near;
        idx_t add_far;
    } step_taps_t;

    // taps on each side of the edge that a mode reads
    function automatic int half_span(input logic wide);
        return wide ? LINE_TAPS / 2 : LINE_TAPS / 4;
    endfunction

    // outermost lane read on the near side
    function automatic int first_tap(input logic wide);
        return LINE_TAPS / 2 - half_span(wide);
    endfunction

    function automatic int out_count(input logic wide);
        return 2 * half_span(wide) - 2;
    endfunction

    function automatic int norm_shift(input logic wide);
        return $clog2(2 * half_span(wide));
    endfunction

    function automatic int round_const(input logic wide);
        return half_span(wide);
    endfunction

    // weight of lane i in the sum for the first output
    function automatic int seed_weight(input logic wide, input int i);
        int b;
        int h;
        b = first_tap(wide);
        h = half_span(wide);
        if (i == b)                        return h - 1;
        else if (i == b + 1)               return 2;
        else if (i >= b + 2 && i <= b + h) return 1;
        else                               return 0;
    endfunction

    // lanes leaving and entering the sum on the way to output k (k >= 1)
    function automatic step_taps_t step_taps(input logic wide, input int k);
        step_taps_t r;
        int b;
        int h;
        int far_add;
        b = first_tap(wide);
        h = half_span(wide);
        far_add = b + k + h;
        if (far_add > LINE_TAPS - 1 - b) far_add = LINE_TAPS - 1 - b;
        r.sub_far  = (k <= h - 1) ? idx_t'(b) : idx_t'(b + k - (h - 1));
        r.sub_near = idx_t'(b + k);
        r.add_near = idx_t'(b + k + 1);
        r.add_far  = idx_t'(far_add);
        return r;
    endfunction

endpackage

// File: rtl/deblk_seed.sv
module deblk_seed
    import deblk_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic                wide,
    input  logic [SAMPLE_W-1:0] taps [LINE_TAPS],
    output logic [ACC_W-1:0]    seed
);

    logic [ACC_W-1:0] term [LINE_TAPS];

    for (genvar g = 0; g < LINE_TAPS; g++) begin : g_term
        assign term[g] = ACC_W'(taps[g]) * ACC_W'(seed_weight(wide, g));
    end

    always_comb begin
        seed = ACC_W'(round_const(wide));
        for (int i = 0; i < LINE_TAPS; i++) begin
            seed = seed + term[i];
        end
    end

endmodule

// File: rtl/deblk_step_upd.sv
module deblk_step_upd
    import deblk_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic                wide,
    input  idx_t                k_next,
    input  logic [ACC_W-1:0]    acc,
    input  logic [SAMPLE_W-1:0] taps [LINE_TAPS],
    output logic [ACC_W-1:0]    acc_next
);

    step_taps_t sel;

    always_comb begin
        sel      = step_taps(wide, int'(k_next));
        acc_next = acc
                 - ACC_W'(taps[sel.sub_far])
                 - ACC_W'(taps[sel.sub_near])
                 + ACC_W'(taps[sel.add_near])
                 + ACC_W'(taps[sel.add_far]);
    end

endmodule

// File: rtl/deblk_norm.sv
module deblk_norm
    import deblk_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic                wide,
    input  logic [ACC_W-1:0]    acc,
    output logic [SAMPLE_W-1:0] y
);

    localparam logic [ACC_W-1:0] SAMPLE_MAX = ACC_W'((1 << SAMPLE_W) - 1);

    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = acc >> norm_shift(wide);
        y = (shifted > SAMPLE_MAX) ? SAMPLE_MAX[SAMPLE_W-1:0] : shifted[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/deblk_smooth.sv
module deblk_smooth
    import deblk_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          wide_mode,
    input  logic                          enable,
    input  logic [LINE_TAPS*SAMPLE_W-1:0] line_in,
    output logic [LINE_TAPS*SAMPLE_W-1:0] line_out,
    output logic                          done
);

    localparam int LINE_W = LINE_TAPS * SAMPLE_W;

    ctl_state_e          state_q;
    ctl_state_e          state_d;
    logic [LINE_W-1:0]   smp_q;
    logic [LINE_W-1:0]   out_q;
    logic                wide_q;
    logic                en_q;
    logic [ACC_W-1:0]    acc_q;
    idx_t                k_q;
    logic                done_q;

    logic [SAMPLE_W-1:0] taps [LINE_TAPS];
    logic [ACC_W-1:0]    seed_sum;
    logic [ACC_W-1:0]    acc_step;
    logic [SAMPLE_W-1:0] norm_val;
    idx_t                k_next;
    idx_t                k_last;
    idx_t                tgt;

    for (genvar g = 0; g < LINE_TAPS; g++) begin : g_unpack
        assign taps[g] = smp_q[g*SAMPLE_W +: SAMPLE_W];
    end

    assign k_next = k_q + idx_t'(1);
    assign k_last = idx_t'(out_count(wide_q) - 1);
    assign tgt    = idx_t'(first_tap(wide_q) + 1 + int'(k_q));

    deblk_seed #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_seed (
        .wide (wide_q),
        .taps (taps),
        .seed (seed_sum)
    );

    deblk_step_upd #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_step (
        .wide     (wide_q),
        .k_next   (k_next),
        .acc      (acc_q),
        .taps     (taps),
        .acc_next (acc_step)
    );

    deblk_norm #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_norm (
        .wide (wide_q),
        .acc  (acc_q),
        .y    (norm_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEED;
            ST_SEED: state_d = ST_RUN;
            ST_RUN:  if (k_q == k_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q  <= '0;
            out_q  <= '0;
            wide_q <= 1'b0;
            en_q   <= 1'b0;
            acc_q  <= '0;
            k_q    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        smp_q  <= line_in;
                        out_q  <= line_in;
                        wide_q <= wide_mode;
                        en_q   <= enable;
                    end
                end
                ST_SEED: begin
                    acc_q <= seed_sum;
                    k_q   <= '0;
                end
                ST_RUN: begin
                    if (en_q) out_q[int'(tgt)*SAMPLE_W +: SAMPLE_W] <= norm_val;
                    acc_q <= acc_step;
                    k_q   <= k_next;
                    if (k_q == k_last) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign line_out = out_q;
    assign done     = done_q;

endmodule

// File: rtl/deblk_smooth_chk.sv
module deblk_smooth_chk
    import deblk_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          done,
    input logic                          state_idle,
    input logic                          wide_q,
    input logic                          en_q,
    input logic [LINE_TAPS*SAMPLE_W-1:0] smp_q,
    input logic [LINE_TAPS*SAMPLE_W-1:0] line_out
);

    localparam int LW = LINE_TAPS * SAMPLE_W;

    logic [5:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n)                  cyc <= '0;
        else if (start && state_idle) cyc <= 6'd1;
        else if (!state_idle)        cyc <= cyc + 6'd1;
    end

    // R5: single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: latency from the accepted start
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == (wide_q ? 6'd16 : 6'd8)));

    // R6: bypass leaves the captured line untouched
    assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !en_q) |-> (line_out == smp_q));

    // R4: outermost lanes are never rewritten
    assert_edges_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (line_out[SAMPLE_W-1:0] == smp_q[SAMPLE_W-1:0]
              && line_out[LW-1 -: SAMPLE_W] == smp_q[LW-1 -: SAMPLE_W]));

    // R4: narrow mode keeps lanes 0..4 and 11..15
    assert_narrow_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (line_out[5*SAMPLE_W-1:0] == smp_q[5*SAMPLE_W-1:0]
              && line_out[LW-1 -: 5*SAMPLE_W] == smp_q[LW-1 -: 5*SAMPLE_W]));

    // R8: idle output holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_idle && !start) |=> $stable(line_out));

endmodule

bind deblk_smooth deblk_smooth_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .state_idle (state_q == deblk_pkg::ST_IDLE),
    .wide_q     (wide_q),
    .en_q       (en_q),
    .smp_q      (smp_q),
    .line_out   (line_out)
);

// File: tb/deblk_smooth_test.sv
module deblk_smooth_test;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam int LW = NL * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          wide_mode = 1'b0;
    logic          enable = 1'b0;
    logic [LW-1:0] line_in = '0;
    logic [LW-1:0] line_out;
    logic          done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deblk_smooth uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wide_mode (wide_mode),
        .enable    (enable),
        .line_in   (line_in),
        .line_out  (line_out),
        .done      (done)
    );

    function automatic logic [7:0] lane(input logic [LW-1:0] v, input int i);
        return v[i*8 +: 8];
    endfunction

    // direct windowed average, written from R2/R3/R4/R6
    function automatic logic [LW-1:0] expect_line(input logic [LW-1:0] v,
                                                  input logic wide, input logic en);
        logic [LW-1:0] r;
        int h, lo, hi, sum, idx;
        r = v;
        if (!en) return r;
        h  = wide ? 8 : 4;
        lo = 8 - h;
        hi = 7 + h;
        for (int t = lo + 1; t <= hi - 1; t++) begin
            sum = int'(lane(v, t)) + h;
            for (int j = -(h - 1); j <= h - 1; j++) begin
                idx = t + j;
                if (idx < lo) idx = lo;
                if (idx > hi) idx = hi;
                sum += int'(lane(v, idx));
            end
            r[t*8 +: 8] = 8'(sum / (2 * h));
        end
        return r;
    endfunction

    task automatic check_line(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: line_out actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one line; returns cycles from accepting edge to done
    task automatic run_line(input logic [LW-1:0] v, input logic wide, input logic en,
                            input bit disturb, output int lat);
        @(negedge clk);
        line_in = v; wide_mode = wide; enable = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 3) begin
                line_in = ~v; wide_mode = ~wide; enable = ~en; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 done in reset", int'(done), 0);
        check_line("R1 line_out in reset", line_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 done after reset", int'(done), 0);
        check_line("R1 line_out after reset", line_out, '0);
    endtask

    task automatic t_narrow;
        logic [LW-1:0] v;
        int lat;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < NL; i++) begin
                case (p)
                    0: v[i*8 +: 8] = 8'(60 + 3 * i);
                    1: v[i*8 +: 8] = (i < 8) ? 8'd40 : 8'd200;
                    2: v[i*8 +: 8] = (i % 2 == 1) ? 8'd250 : 8'd5;
                    default: v[i*8 +: 8] = 8'($urandom_range(0, 255));
                endcase
            end
            run_line(v, 1'b0, 1'b1, 1'b0, lat);
            check_line("R2/R4 narrow result", line_out, expect_line(v, 1'b0, 1'b1));
            check_int("R5 narrow latency", lat, 7);
            @(negedge clk);
            check_int("R5 done falls", int'(done), 0);
        end
    endtask

    task automatic t_wide;
        logic [LW-1:0] v;
        int lat;
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < NL; i++) begin
                case (p)
                    0: v[i*8 +: 8] = 8'(100 + i);
                    1: v[i*8 +: 8] = (i < 8) ? 8'd220 : 8'd16;
                    2: v[i*8 +: 8] = 8'(17 * i);
                    default: v[i*8 +: 8] = 8'($urandom_range(0, 255));
                endcase
            end
            run_line(v, 1'b1, 1'b1, 1'b0, lat);
            check_line("R3/R4 wide result", line_out, expect_line(v, 1'b1, 1'b1));
            check_int("R5 wide latency", lat, 15);
        end
    endtask

    task automatic t_bypass;
        logic [LW-1:0] v;
        int lat;
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < NL; i++) v[i*8 +: 8] = 8'($urandom_range(0, 255));
            run_line(v, 1'(m), 1'b0, 1'b0, lat);
            check_line("R6 bypass line", line_out, v);
            check_int("R6 bypass latency", lat, (m == 1) ? 15 : 7);
        end
    endtask

    task automatic t_busy_start;
        logic [LW-1:0] v;
        int lat;
        for (int i = 0; i < NL; i++) v[i*8 +: 8] = 8'($urandom_range(0, 255));
        run_line(v, 1'b1, 1'b1, 1'b1, lat);
        check_line("R7 busy inputs ignored", line_out, expect_line(v, 1'b1, 1'b1));
        check_int("R7 busy timing", lat, 15);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check_int("R7 no extra run", int'(done), 0);
    endtask

    task automatic t_hold;
        logic [LW-1:0] held;
        held = line_out;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            line_in = {4{$urandom()}};
            wide_mode = 1'(c);
            enable = 1'b1;
        end
        check_line("R8 idle hold", line_out, held);
    endtask

    task automatic t_extremes;
        int lat;
        for (int m = 0; m < 2; m++) begin
            run_line({LW{1'b1}}, 1'(m), 1'b1, 1'b0, lat);
            check_line("R9 all max", line_out, {LW{1'b1}});
            run_line('0, 1'(m), 1'b1, 1'b0, lat);
            check_line("R9 all zero", line_out, '0);
        end
    endtask

    initial begin
        t_reset();
        t_narrow();
        t_wide();
        t_bypass();
        t_busy_start();
        t_hold();
        t_extremes();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule